// File: doc/BRIEF.md
# Hardware Return Address Stack

This block keeps the return addresses of a processor core in dedicated storage, apart from program and data memory. A call, an interrupt acknowledge or a software push places the current program counter on the stack. A return takes the newest address back off and presents it to the fetch logic. A software pop discards the newest address without returning through it. Storage is 31 entries of 21 bits each. A 5-bit pointer indexes the stack. Pointer value 0 means "empty" and has no storage behind it.

A small byte-wide register port lets software read and write the pointer and the entry at the top of the stack. The port has one status/pointer register and three top-of-stack byte registers, so software can spill the stack to memory and restore it. Two sticky flags record a full stack and an underflow. A configuration input chooses what happens when the stack fills. With it set, the block asks the device to reset and rewinds the pointer. With it clear, the pointer stops at the top entry and that entry is never overwritten.

Top module: `retstack_top`

## Requirements
- R1: While `rst_n` or `por_n` is low at a rising edge, the pointer becomes 0, `ret_addr` becomes 0 and `dev_rst_req` becomes 0. Only `por_n` low clears the full and underflow flags.
- R2: A push (`call_push` or `sw_push`) at pointer p below 30 moves the pointer to p+1 and stores `pc_in` in entry p+1. The stored value then reads back through the top-of-stack registers.
- R3: A return pop (`ret_pop`) at pointer p above 0 loads entry p into `ret_addr` at that edge and moves the pointer to p-1. `ret_addr` changes at no other time except reset.
- R4: A software pop (`sw_pop`) at pointer p above 0 moves the pointer to p-1 and leaves `ret_addr` unchanged.
- R5: Any pop at pointer 0 leaves the pointer at 0 and sets the underflow flag. A return pop at pointer 0 also loads 0 into `ret_addr`.
- R6: A push that brings the pointer to 31, or a push at pointer 31, sets the full flag. When `ovf_rst_en` is 1, that push still stores its value and raises `dev_rst_req` for exactly the next cycle. The pointer becomes 0 and the full flag stays set.
- R7: When `ovf_rst_en` is 0, the push that reaches 31 leaves the pointer at 31. Later pushes keep the pointer at 31, leave entry 31 unchanged and keep the full flag set.
- R8: Each flag is cleared only by `por_n` or by a status-register write with that flag's bit at 0. Writing a 1 to a flag bit never sets it. Neither `rst_n` nor an overflow reset clears a flag.
- R9: Register map on `reg_sel`. Select 0 is status: bit 7 full, bit 6 underflow, bit 5 reads 0, bits 4:0 the pointer; a write there loads bits 4:0 into the pointer. Select 1 is entry bits 7:0. Select 2 is entry bits 15:8. Select 3 is entry bits 20:16 in bits 4:0, with bits 7:5 reading 0. Reads are combinational. Writes take effect at the rising edge.
- R10: At pointer 0 the three top-of-stack registers read 0, and writes to them change no entry.
- R11: A push and a pop in the same cycle perform only the push. During any push or pop, a register write that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; rewinds the pointer, keeps the flags |
| por_n | input | 1 | Synchronous active-low power-on reset; also clears the flags |
| call_push | input | 1 | Push from a call or interrupt acknowledge |
| ret_pop | input | 1 | Pop from a return; loads `ret_addr` |
| sw_push | input | 1 | Software push of `pc_in` |
| sw_pop | input | 1 | Software pop; discards the top entry |
| pc_in | input | 21 | Address to push |
| ovf_rst_en | input | 1 | 1: a full stack requests a device reset; 0: the pointer saturates at 31 |
| reg_sel | input | 2 | Register select (0 status, 1 low, 2 high, 3 upper) |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` |
| ret_addr | output | 21 | Address taken by the latest return pop |
| stk_full | output | 1 | Sticky full flag |
| stk_unf | output | 1 | Sticky underflow flag |
| dev_rst_req | output | 1 | One-cycle request for a device reset on overflow |

## Verification
Every effect of a request lands at the rising edge that samples the request. This covers pointer moves, flag changes, stored entries, register writes, `ret_addr` and the one-cycle `dev_rst_req` pulse. Because `reg_rdata` is combinational, the new pointer and entry can be read in the cycle straight after that edge. The bench drives each request on a falling edge and samples results at the next falling edge, one rising edge later. It then checks `dev_rst_req` again one further cycle on to confirm it has dropped. The pointer is swept through every level from 0 to 31 and back, with every stored word checked against arithmetic expectations.

// File: rtl/retstack_pkg.sv
package retstack_pkg;

   typedef enum logic [1:0] {
      SEL_STAT  = 2'd0,
      SEL_TOS_L = 2'd1,
      SEL_TOS_M = 2'd2,
      SEL_TOS_U = 2'd3
   } rs_sel_e;

   localparam int STAT_FULL_BIT = 7;
   localparam int STAT_UNF_BIT  = 6;
   localparam int LANE_CNT      = 3;

   typedef struct packed {
      logic push;
      logic pop;
      logic hw_pop;
   } rs_op_t;

endpackage

// File: rtl/retstack_ptr.sv
module retstack_ptr #(
   parameter int DEPTH = 31,
   localparam int PTR_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             por_n,
   input  retstack_pkg::rs_op_t op,
   input  logic             ovf_rst_en,
   input  logic             stat_we,
   input  logic             clr_full,
   input  logic             clr_unf,
   input  logic [PTR_W-1:0] ptr_wval,
   output logic [PTR_W-1:0] ptr,
   output logic             full,
   output logic             unf,
   output logic             dev_rst_req,
   output logic             mem_we,
   output logic [PTR_W-1:0] mem_idx
);

   localparam logic [PTR_W-1:0] TOP = PTR_W'(DEPTH);

   logic [PTR_W-1:0] ptr_q, ptr_d, next_up;
   logic             full_q, full_d, unf_q, unf_d, rst_q, rst_d;
   logic             at_top, at_bot, hits_top, reg_ok, live;

   assign live     = rst_n && por_n;
   assign at_top   = (ptr_q == TOP);
   assign at_bot   = (ptr_q == '0);
   assign next_up  = ptr_q + 1'b1;
   assign hits_top = op.push && (at_top || next_up == TOP);
   assign reg_ok   = stat_we && !op.push && !op.pop;
   assign mem_we   = op.push && !at_top;
   assign mem_idx  = next_up;

   always_comb begin
      ptr_d = ptr_q;
      if (op.push) begin
         if (hits_top) ptr_d = ovf_rst_en ? '0 : TOP;
         else          ptr_d = next_up;
      end else if (op.pop) begin
         ptr_d = at_bot ? '0 : ptr_q - 1'b1;
      end else if (reg_ok) begin
         ptr_d = (ptr_wval > TOP) ? TOP : ptr_wval;
      end
   end

   always_comb begin
      full_d = full_q | hits_top;
      unf_d  = unf_q | (op.pop && !op.push && at_bot);
      if (reg_ok && clr_full) full_d = 1'b0;
      if (reg_ok && clr_unf)  unf_d  = 1'b0;
      rst_d = hits_top && ovf_rst_en;
   end

   always_ff @(posedge clk) begin
      if (!live) begin
         ptr_q <= '0;
         rst_q <= 1'b0;
      end else begin
         ptr_q <= ptr_d;
         rst_q <= rst_d;
      end
   end

   always_ff @(posedge clk) begin
      if (!por_n) begin
         full_q <= 1'b0;
         unf_q  <= 1'b0;
      end else if (rst_n) begin
         full_q <= full_d;
         unf_q  <= unf_d;
      end
   end

   assign ptr         = ptr_q;
   assign full        = full_q;
   assign unf         = unf_q;
   assign dev_rst_req = rst_q;

   // R2
   push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (op.push && ptr_q < TOP - 1'b1) |=> ptr_q == $past(ptr_q) + 1'b1);

   // R5
   unf_set_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (op.pop && !op.push && at_bot) |=> (unf_q && ptr_q == '0));

   // R6
   rst_ptr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      rst_q |-> (ptr_q == '0 && full_q));

   // R8
   full_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      (full_q && !(reg_ok && clr_full)) |=> full_q);

   // R9
   ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      ptr_q <= TOP);

endmodule

// File: rtl/retstack_mem.sv
module retstack_mem #(
   parameter int DEPTH  = 31,
   parameter int ADDR_W = 21,
   localparam int PTR_W = $clog2(DEPTH + 1),
   localparam int UP_W  = ADDR_W - 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_we,
   input  logic [PTR_W-1:0]  push_idx,
   input  logic [ADDR_W-1:0] push_data,
   input  logic [2:0]        lane_we,
   input  logic [PTR_W-1:0]  lane_idx,
   input  logic [7:0]        lane_data,
   input  logic [PTR_W-1:0]  rd_idx,
   output logic [ADDR_W-1:0] rd_data
);

   logic [DEPTH:0][ADDR_W-1:0] ent_v;
   logic unused_lane;

   assign unused_lane = ^lane_data;
   assign ent_v[0] = '0;

   for (genvar e = 1; e <= DEPTH; e++) begin : g_ent
      logic [ADDR_W-1:0] q;
      always_ff @(posedge clk) begin
         if (push_we && push_idx == PTR_W'(e)) begin
            q <= push_data;
         end else if (lane_idx == PTR_W'(e)) begin
            if (lane_we[0]) q[7:0]        <= lane_data;
            if (lane_we[1]) q[15:8]       <= lane_data;
            if (lane_we[2]) q[ADDR_W-1:16] <= lane_data[UP_W-1:0];
         end
      end
      assign ent_v[e] = q;
   end

   always_comb begin
      rd_data = '0;
      if (int'(rd_idx) <= DEPTH) rd_data = ent_v[rd_idx];
   end

   // R10
   idx0_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_we |-> push_idx != '0);

   // R10
   idx0_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_we != 3'b000) |-> lane_idx != '0);

endmodule

// File: rtl/retstack_regif.sv
module retstack_regif #(
   parameter int DEPTH  = 31,
   parameter int ADDR_W = 21,
   localparam int PTR_W = $clog2(DEPTH + 1)
) (
   input  logic [1:0]        sel,
   input  logic              we,
   input  logic [7:0]        wdata,
   input  logic              busy,
   input  logic [PTR_W-1:0]  ptr,
   input  logic              full,
   input  logic              unf,
   input  logic [ADDR_W-1:0] tos,
   output logic [7:0]        rdata,
   output logic              stat_we,
   output logic              clr_full,
   output logic              clr_unf,
   output logic [PTR_W-1:0]  ptr_wval,
   output logic [2:0]        lane_we
);
   import retstack_pkg::*;

   rs_sel_e sel_e;
   logic    lane_ok;
   logic    unused_wd;

   assign sel_e     = rs_sel_e'(sel);
   assign lane_ok   = we && !busy && (ptr != '0);
   assign stat_we   = we && (sel_e == SEL_STAT);
   assign clr_full  = !wdata[STAT_FULL_BIT];
   assign clr_unf   = !wdata[STAT_UNF_BIT];
   assign ptr_wval  = wdata[PTR_W-1:0];
   assign unused_wd = wdata[5];

   always_comb begin
      lane_we = 3'b000;
      case (sel_e)
         SEL_TOS_L: lane_we[0] = lane_ok;
         SEL_TOS_M: lane_we[1] = lane_ok;
         SEL_TOS_U: lane_we[2] = lane_ok;
         default:   lane_we    = 3'b000;
      endcase
   end

   always_comb begin
      rdata = '0;
      case (sel_e)
         SEL_STAT: begin
            rdata[STAT_FULL_BIT] = full;
            rdata[STAT_UNF_BIT]  = unf;
            rdata[PTR_W-1:0]     = ptr;
         end
         SEL_TOS_L: rdata = tos[7:0];
         SEL_TOS_M: rdata = tos[15:8];
         SEL_TOS_U: rdata = 8'(tos[ADDR_W-1:16]);
         default:   rdata = '0;
      endcase
   end

endmodule

// File: rtl/retstack_top.sv
module retstack_top #(
   parameter int DEPTH  = 31,
   parameter int ADDR_W = 21,
   localparam int PTR_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_n,
   input  logic              call_push,
   input  logic              ret_pop,
   input  logic              sw_push,
   input  logic              sw_pop,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic              ovf_rst_en,
   input  logic [1:0]        reg_sel,
   input  logic              reg_we,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic [ADDR_W-1:0] ret_addr,
   output logic              stk_full,
   output logic              stk_unf,
   output logic              dev_rst_req
);
   import retstack_pkg::*;

   if (DEPTH < 1 || DEPTH > 31) begin : g_bad_depth
      $error("retstack_top: DEPTH must lie in 1..31");
   end
   if (ADDR_W < 17 || ADDR_W > 24) begin : g_bad_width
      $error("retstack_top: ADDR_W must lie in 17..24");
   end

   rs_op_t            op;
   logic [PTR_W-1:0]  ptr, mem_idx, ptr_wval;
   logic              mem_we, stat_we, clr_full, clr_unf;
   logic [2:0]        lane_we;
   logic [ADDR_W-1:0] tos, ret_q;

   assign op.push   = call_push || sw_push;
   assign op.pop    = ret_pop || sw_pop;
   assign op.hw_pop = ret_pop && !op.push;

   retstack_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk(clk), .rst_n(rst_n), .por_n(por_n), .op(op),
      .ovf_rst_en(ovf_rst_en), .stat_we(stat_we),
      .clr_full(clr_full), .clr_unf(clr_unf), .ptr_wval(ptr_wval),
      .ptr(ptr), .full(stk_full), .unf(stk_unf),
      .dev_rst_req(dev_rst_req), .mem_we(mem_we), .mem_idx(mem_idx)
   );

   retstack_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
      .clk(clk), .rst_n(rst_n), .push_we(mem_we), .push_idx(mem_idx),
      .push_data(pc_in), .lane_we(lane_we), .lane_idx(ptr),
      .lane_data(reg_wdata), .rd_idx(ptr), .rd_data(tos)
   );

   retstack_regif #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_regif (
      .sel(reg_sel), .we(reg_we), .wdata(reg_wdata),
      .busy(op.push || op.pop), .ptr(ptr), .full(stk_full), .unf(stk_unf),
      .tos(tos), .rdata(reg_rdata), .stat_we(stat_we),
      .clr_full(clr_full), .clr_unf(clr_unf), .ptr_wval(ptr_wval),
      .lane_we(lane_we)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || !por_n) ret_q <= '0;
      else if (op.hw_pop)   ret_q <= tos;
   end
   assign ret_addr = ret_q;

   // R3
   ret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      !op.hw_pop |=> $stable(ret_q));

   // R11
   pop_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (op.push && op.pop && ptr == '0) |=> ptr != '0 || stk_full);

endmodule

// File: tb/retstack_top_bench.sv
module retstack_top_bench;

   logic        clk = 1'b0;
   logic        rst_n, por_n, call_push, ret_pop, sw_push, sw_pop, ovf_rst_en;
   logic [20:0] pc_in;
   logic [1:0]  reg_sel;
   logic        reg_we;
   logic [7:0]  reg_wdata, reg_rdata;
   logic [20:0] ret_addr;
   logic        stk_full, stk_unf, dev_rst_req;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   retstack_top u_retstack_top (
      .clk(clk), .rst_n(rst_n), .por_n(por_n), .call_push(call_push),
      .ret_pop(ret_pop), .sw_push(sw_push), .sw_pop(sw_pop), .pc_in(pc_in),
      .ovf_rst_en(ovf_rst_en), .reg_sel(reg_sel), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ret_addr(ret_addr),
      .stk_full(stk_full), .stk_unf(stk_unf), .dev_rst_req(dev_rst_req)
   );

   function automatic logic [20:0] pcv(input int i);
      return 21'((i * 40503 + 1234) * 2);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input logic [1:0] s, output logic [7:0] v);
      reg_sel = s;
      #1;
      v = reg_rdata;
   endtask

   task automatic rd_tos(output logic [20:0] v);
      logic [7:0] b0, b1, b2;
      rd(2'd1, b0);
      rd(2'd2, b1);
      rd(2'd3, b2);
      v = {b2[4:0], b1, b0};
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      reg_sel = s; reg_wdata = d; reg_we = 1'b1;
      tick();
      reg_we = 1'b0;
   endtask

   task automatic push(input logic [20:0] pc, input bit sw);
      pc_in = pc;
      if (sw) sw_push = 1'b1; else call_push = 1'b1;
      tick();
      sw_push = 1'b0; call_push = 1'b0;
   endtask

   task automatic pop(input bit sw);
      if (sw) sw_pop = 1'b1; else ret_pop = 1'b1;
      tick();
      sw_pop = 1'b0; ret_pop = 1'b0;
   endtask

   function automatic logic [7:0] stat(input bit f, input bit u, input int p);
      return {f, u, 1'b0, 5'(p)};
   endfunction

   initial begin
      #4000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0]  s;
      logic [20:0] t, held;
      rst_n = 1'b0; por_n = 1'b0; call_push = 1'b0; ret_pop = 1'b0;
      sw_push = 1'b0; sw_pop = 1'b0; ovf_rst_en = 1'b0; pc_in = '0;
      reg_sel = '0; reg_we = 1'b0; reg_wdata = '0;
      tick(); tick();
      rst_n = 1'b1; por_n = 1'b1;
      tick();

      // R1 reset state
      rd(2'd0, s);
      chk("R1 status", s, 8'h00);
      chk("R1 ret_addr", ret_addr, 0);
      chk("R1 dev_rst_req", dev_rst_req, 0);

      // R2 fill to 30 with alternating push sources, R9 readback
      for (int i = 1; i <= 30; i++) begin
         push(pcv(i), i[0]);
         rd(2'd0, s);
         chk("R2 pointer after push", s, stat(0, 0, i));
         rd_tos(t);
         chk("R2 R9 tos value", t, pcv(i));
      end
      rd(2'd3, s);
      chk("R9 upper bits 7:5 zero", s[7:5], 0);

      // R7 31st push saturates
      push(pcv(31), 0);
      rd(2'd0, s);
      chk("R7 full at 31", s, stat(1, 0, 31));
      chk("R7 no reset request", dev_rst_req, 0);
      push(21'h0ABCDE, 1);
      rd(2'd0, s);
      chk("R7 pointer stays 31", s, stat(1, 0, 31));
      rd_tos(t);
      chk("R7 entry 31 kept", t, pcv(31));

      // R3 / R4 unwind with alternating pop kinds
      held = ret_addr;
      for (int k = 31; k >= 1; k--) begin
         pop(k[0] == 1'b0);
         rd(2'd0, s);
         chk("R3 R4 pointer after pop", s, stat(1, 0, k - 1));
         if (k[0] == 1'b0) begin
            chk("R4 ret_addr unchanged", ret_addr, held);
         end else begin
            chk("R3 ret_addr", ret_addr, pcv(k));
            held = pcv(k);
         end
      end

      // R5 underflow
      pop(0);
      rd(2'd0, s);
      chk("R5 underflow status", s, stat(1, 1, 0));
      chk("R5 ret_addr zero", ret_addr, 0);
      pop(1);
      rd(2'd0, s);
      chk("R5 sw pop at 0", s, stat(1, 1, 0));

      // R8 flag clearing by writing 0 only
      wr(2'd0, 8'h40);
      rd(2'd0, s);
      chk("R8 clear full only", s, stat(0, 1, 0));
      wr(2'd0, 8'h80 | 8'd5);
      rd(2'd0, s);
      chk("R8 R9 clear unf no set full", s, stat(0, 0, 5));

      // R8 rst_n keeps flags, por_n clears
      wr(2'd0, 8'd0);
      pop(0);
      rst_n = 1'b0; tick(); tick(); rst_n = 1'b1;
      rd(2'd0, s);
      chk("R8 R1 rst_n keeps unf", s, stat(0, 1, 0));
      por_n = 1'b0; tick(); por_n = 1'b1;
      rd(2'd0, s);
      chk("R1 por clears flags", s, stat(0, 0, 0));

      // R10 tos at pointer 0
      rd_tos(t);
      chk("R10 tos reads zero", t, 0);
      wr(2'd1, 8'hAA);
      wr(2'd2, 8'hBB);
      wr(2'd0, 8'd1);
      rd_tos(t);
      chk("R10 write at 0 ignored", t, pcv(1));

      // R9 lane writes at pointer 1, then return through them
      wr(2'd1, 8'h12);
      wr(2'd2, 8'h34);
      wr(2'd3, 8'hFF);
      rd(2'd3, s);
      chk("R9 upper lane masked", s, 8'h1F);
      pop(0);
      chk("R3 R9 ret of written entry", ret_addr, 21'h1F3412);

      // R11 push+pop+register write together
      pc_in = 21'h00F0F0; call_push = 1'b1; ret_pop = 1'b1;
      reg_sel = 2'd0; reg_wdata = 8'd5; reg_we = 1'b1;
      tick();
      call_push = 1'b0; ret_pop = 1'b0; reg_we = 1'b0;
      rd(2'd0, s);
      chk("R11 push wins", s, stat(0, 0, 1));
      chk("R11 ret_addr unchanged", ret_addr, 21'h1F3412);
      rd_tos(t);
      chk("R11 pushed value", t, 21'h00F0F0);

      // R6 overflow with reset request
      ovf_rst_en = 1'b1;
      wr(2'd0, 8'd29);
      push(pcv(40), 0);
      rd(2'd0, s);
      chk("R6 pointer 30", s, stat(0, 0, 30));
      chk("R6 no early reset", dev_rst_req, 0);
      push(pcv(41), 1);
      chk("R6 reset request", dev_rst_req, 1);
      rd(2'd0, s);
      chk("R6 pointer rewound full set", s, stat(1, 0, 0));
      tick();
      chk("R6 request one cycle", dev_rst_req, 0);
      wr(2'd0, 8'h80 | 8'd31);
      rd_tos(t);
      chk("R6 31st value stored", t, pcv(41));
      rst_n = 1'b0; tick(); rst_n = 1'b1;
      rd(2'd0, s);
      chk("R8 full survives rst_n", s, stat(1, 0, 0));

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule